// File: doc/BRIEF.md
# Clock Throttle Stop-Clock Timer

This block produces an active-low stop-clock request used to throttle a processor's clock. While a throttle enable input is high, the output alternates between an asserted (low) phase and a negated (high) phase. Both phases have the same length, and that length is derived from an 8-bit programmable value held in a read/write register. The block runs from the PCI clock. Each phase lasts `1 + PRESCALE * (N + 1)` clocks, where N is the programmed value and PRESCALE is a fixed divider that defaults to 1056.

The programmed value is captured only when an asserted phase begins. The negated phase that follows uses that same captured value. A write made during a phase therefore changes nothing until the next assertion. When the enable drops, the output returns high on the next clock and all timing state is discarded. A later enable then starts a fresh asserted phase of full length.

Top module: `clock_throttle_timer`

## Requirements
- R1: After reset the register reads 8'h00 and the stop-clock output is high (negated).
- R2: A write (cfg_we high at a clock edge) places cfg_wdata in the register, and cfg_rdata shows the new value from the next cycle on.
- R3: While thr_en is low, stop_clk_n is high one clock later and stays high.
- R4: When thr_en rises while the block is idle, stop_clk_n goes low at the next clock edge.
- R5: An asserted (low) phase lasts exactly 1 + PRESCALE*(N+1) clocks, where N is the register value at the start of that phase (PRESCALE defaults to 1056).
- R6: The negated (high) phase that follows an asserted phase lasts exactly 1 + PRESCALE*(N+1) clocks, using the same N captured for the preceding asserted phase.
- R7: A write made during a phase does not change the current phase or the following negated phase. It takes effect at the next assertion.
- R8: With thr_en held high, low and high phases keep alternating without a gap.
- R9: Dropping thr_en in the middle of a phase clears the timer, so that re-enabling yields a full-length asserted phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| thr_en | input | 1 | Throttle enable (from the control register bit) |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (programmed low-time value) |
| stop_clk_n | output | 1 | Active-low stop-clock request |

## Verification
The hardest situation to reach is a register write landing inside a running phase. It must change neither that phase nor the negated phase after it, and it must show up only at the following assertion. The stimulus starts throttling with value 0. It rewrites the register partway through the low phase. It then measures three consecutive phase lengths and expects the old length twice and then the new one. Disabling partway through a phase and then re-enabling covers the counter clearing, because any leftover prescaler or block count would shorten the next low phase.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/thr_valreg.sv
module thr_valreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/thr_prescaler.sv
module thr_prescaler #(
  parameter int DIV = 1056,
  parameter int W   = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/thr_blkcnt.sv
module thr_blkcnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                         cnt_d = load_val;
    else if (dec && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clock_throttle_timer.sv
module clock_throttle_timer #(
  parameter int PRESCALE = 1056,
  parameter int VAL_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_en,
  input  logic             cfg_we,
  input  logic [VAL_W-1:0] cfg_wdata,
  output logic [VAL_W-1:0] cfg_rdata,
  output logic             stop_clk_n
);
  import thr_pkg::*;

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int BLK_W = VAL_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_m1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1_q <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_m1_q <= 1'b1;
      rst_s    <= rst_m1_q;
    end
  end

  phase_e             phase_q, phase_d;
  logic               first_q, first_d;
  logic [VAL_W-1:0]   held_q, held_d;
  logic               out_n_q, out_n_d;
  logic               run, tick, last, phase_end;
  logic               blk_load, pre_clr;
  logic [BLK_W-1:0]   blk_val;
  logic [VAL_W-1:0]   val_q;

  thr_valreg #(.W(VAL_W)) u_val (
    .clk(clk), .rst_n(rst_s), .we(cfg_we), .wdata(cfg_wdata), .q(val_q)
  );

  thr_prescaler #(.DIV(PRESCALE), .W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .clr(pre_clr), .run(run), .tick(tick)
  );

  thr_blkcnt #(.W(BLK_W)) u_blk (
    .clk(clk), .rst_n(rst_s), .load(blk_load), .load_val(blk_val),
    .dec(tick), .last(last)
  );

  assign run       = (phase_q != PH_IDLE) && !first_q;
  assign phase_end = tick && last;

  always_comb begin
    phase_d  = phase_q;
    first_d  = 1'b0;
    held_d   = held_q;
    blk_load = 1'b0;
    blk_val  = '0;
    pre_clr  = 1'b0;
    if (!thr_en) begin
      phase_d  = PH_IDLE;
      blk_load = 1'b1;
      pre_clr  = 1'b1;
    end else if (phase_q == PH_IDLE) begin
      phase_d  = PH_LOW;
      first_d  = 1'b1;
      held_d   = val_q;
      blk_load = 1'b1;
      blk_val  = BLK_W'(val_q) + 1'b1;
      pre_clr  = 1'b1;
    end else if (phase_end) begin
      first_d  = 1'b1;
      blk_load = 1'b1;
      pre_clr  = 1'b1;
      if (phase_q == PH_LOW) begin
        phase_d = PH_HIGH;
        blk_val = BLK_W'(held_q) + 1'b1;
      end else begin
        phase_d = PH_LOW;
        held_d  = val_q;
        blk_val = BLK_W'(val_q) + 1'b1;
      end
    end
    out_n_d = (phase_d != PH_LOW);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phase_q <= PH_IDLE;
      first_q <= 1'b0;
      held_q  <= '0;
      out_n_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      first_q <= first_d;
      held_q  <= held_d;
      out_n_q <= out_n_d;
    end
  end

  assign stop_clk_n = out_n_q;
  assign cfg_rdata  = val_q;
endmodule

// File: rtl/thr_chk.sv
module thr_chk #(
  parameter int PRESCALE = 1056,
  parameter int VAL_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             thr_en,
  input logic             cfg_we,
  input logic [VAL_W-1:0] cfg_wdata,
  input logic [VAL_W-1:0] cfg_rdata,
  input logic             stop_clk_n,
  input logic [VAL_W-1:0] held
);
  logic prev_q;
  int   len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      len_q  <= 0;
    end else begin
      prev_q <= stop_clk_n;
      if (stop_clk_n != prev_q) len_q <= 1;
      else                      len_q <= len_q + 1;
    end
  end

  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  a_r3_disable_negates: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_en |=> stop_clk_n);

  a_r4_enable_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_en && $past(!thr_en)) |=> !stop_clk_n);

  a_r5_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_clk_n) && $past(thr_en) && !prev_q) |->
      len_q == 1 + PRESCALE * (int'(held) + 1));
endmodule

bind clock_throttle_timer thr_chk #(.PRESCALE(PRESCALE), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .thr_en(thr_en), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stop_clk_n(stop_clk_n),
  .held(held_q)
);

// File: tb/sim_clock_throttle_timer.sv
module sim_clock_throttle_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 1056;
  localparam int NVEC = 4;
  localparam logic [7:0] VEC_N [NVEC] = '{8'd0, 8'd1, 8'd3, 8'd2};
  localparam int VEC_L [NVEC] = '{1 + PRE*1, 1 + PRE*2, 1 + PRE*4, 1 + PRE*3};

  logic clk = 1'b0;
  logic rst_n, thr_en, cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic stop_clk_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_throttle_timer #(.PRESCALE(PRE), .VAL_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stop_clk_n(stop_clk_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // counts negedge samples while the output holds the given level
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (stop_clk_n == lvl && n < 400000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; thr_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cfg_rdata == 8'h00, "R1 reg", cfg_rdata, 0);
    chk(stop_clk_n == 1'b1, "R1 out", stop_clk_n, 1);

    // table walk: R2 readback, R4 assert, R5 low length, R6 high length, R8 alternation
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC_N[i]);
      chk(cfg_rdata == VEC_N[i], "R2 readback", cfg_rdata, VEC_N[i]);
      thr_en = 1'b1;
      @(negedge clk);
      chk(stop_clk_n == 1'b0, "R4 assert", stop_clk_n, 0);
      run_len(1'b0, n);
      chk(n == VEC_L[i], "R5 low length", n, VEC_L[i]);
      run_len(1'b1, n);
      chk(n == VEC_L[i], "R6 high length", n, VEC_L[i]);
      chk(stop_clk_n == 1'b0, "R8 realternate", stop_clk_n, 0);
      thr_en = 1'b0;
      @(negedge clk);
      chk(stop_clk_n == 1'b1, "R3 disable", stop_clk_n, 1);
      repeat (2) @(negedge clk);
    end

    // R7: write mid-phase takes effect only at next assertion
    wr(8'd0);
    thr_en = 1'b1;
    @(negedge clk);
    repeat (200) @(negedge clk);
    wr(8'd2);
    chk(cfg_rdata == 8'd2, "R2 midphase write", cfg_rdata, 2);
    run_len(1'b0, n);
    chk(n == 1 + PRE - 201, "R7 current low unchanged", n, 1 + PRE - 201);
    run_len(1'b1, n);
    chk(n == 1 + PRE, "R7 following high unchanged", n, 1 + PRE);
    run_len(1'b0, n);
    chk(n == 1 + PRE*3, "R7 next low uses new value", n, 1 + PRE*3);

    // R9: disable during high phase, then during low phase; re-enable gives full length
    repeat (500) @(negedge clk);
    thr_en = 1'b0;
    @(negedge clk);
    chk(stop_clk_n == 1'b1, "R3 disable in high", stop_clk_n, 1);
    wr(8'd0);
    thr_en = 1'b1;
    @(negedge clk);
    repeat (700) @(negedge clk);
    thr_en = 1'b0;
    @(negedge clk);
    chk(stop_clk_n == 1'b1, "R9 disable mid low", stop_clk_n, 1);
    repeat (5) @(negedge clk);
    chk(stop_clk_n == 1'b1, "R3 stays high", stop_clk_n, 1);
    thr_en = 1'b1;
    @(negedge clk);
    run_len(1'b0, n);
    chk(n == 1 + PRE, "R9 full low after re-enable", n, 1 + PRE);
    thr_en = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule